// File: doc/BRIEF.md
# SPI flash command sequencer

This block is the byte-level command engine of a serial NOR flash slave. A bit shifter in front of it delivers one received byte per strobe while chip select is low. For each accepted byte the block returns one response byte on the next cycle. It decodes opcodes and gathers the address and dummy bytes that follow. It then streams array bytes for reads, passes page-program bytes and erase requests to a separate program/erase engine, and answers status and identification reads from a small response buffer. It also holds the write-enable latch.

Array reads use a combinational read port: the block presents the current address, and the array returns the byte in the same cycle. The manufacturer byte of the identification code is a parameter. It also decides how many bytes the dual and quad I/O reads collect before data starts. A falling edge on the active-low chip select abandons any command in progress. The write-enable latch keeps its value across a falling edge.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, tx_valid_o, tx_byte_o, prog_req_o and erase_req_o are 0 and the write-enable latch is clear, so a status read returns 0x00.
- R2: Each byte strobed while cs_ni is low gives one tx_valid_o pulse on the following cycle. A byte strobed while cs_ni is high gives no pulse, no engine request, and no change of state or latch.
- R3: Opcode 0x03 takes three address bytes, most significant first. Each later byte returns the array byte at the current address, and the address then advances. The opcode and address bytes answer 0x00.
- R4: Opcodes 0x0B, 0x3B and 0x6B take four bytes (three address bytes and one dummy byte) before data is returned.
- R5: Opcode 0xBB takes 4 bytes when the manufacturer byte is 0xEF or 0x01 and 5 bytes otherwise. Opcode 0xEB takes 6 bytes or 8 bytes under the same rule.
- R6: The read address wraps from MEM_BYTES-1 to 0.
- R7: After opcode 0x02, 0xA2 or 0x32 and three address bytes, each byte pulses prog_req_o with prog_addr_o equal to the current address and prog_data_o equal to the byte. The address then advances. The response is 0x00.
- R8: 0x06 sets the write-enable latch and 0x04 clears it. 0x05 returns one byte with the latch in bit 1 and all other bits 0, then returns to opcode decoding.
- R9: 0x9F returns the identification code, most significant byte first. This is three bytes when EXT_ID is zero. Otherwise it is five bytes, with the two EXT_ID bytes last, most significant first. The block then returns to opcode decoding.
- R10: 0x01 with the latch set takes one byte and then clears the latch. With the latch clear, 0x01 is ignored and the next byte is decoded as an opcode.
- R11: With the latch set, 0x20, 0x52 and 0xD8 pulse erase_req_o after their third address byte, with erase_kind_o 0, 1 or 2 and the collected address. 0xC7 pulses erase_req_o at once with kind 3 and address 0. With the latch clear, no erase request is made.
- R12: Opcode 0x00 and undefined opcodes answer 0x00 and leave the block decoding opcodes.
- R13: A falling edge of cs_ni returns the block to opcode decoding and clears its byte counters. A byte strobed in the same cycle as the edge is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Response byte strobe, one cycle after an accepted byte |
| tx_byte_o | output | 8 | Response byte |
| mem_addr_o | output | 24 | Array read address |
| mem_data_i | input | 8 | Array read data, combinational from mem_addr_o |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | 24 | Program address |
| prog_data_o | output | 8 | Program data byte |
| erase_req_o | output | 1 | Erase request pulse |
| erase_kind_o | output | 2 | Erase size: 0 small, 1 medium, 2 sector, 3 whole array |
| erase_addr_o | output | 24 | Erase address |

## Verification
A falling edge of chip select and a byte strobe can arrive in the same cycle. In that case the reset to idle and the opcode decode must both take effect. The bench provokes this by lowering cs_ni and raising rx_valid_i together in the middle of a read. It then judges the result by the next response: it must be the status byte with the latch set, not array data and not a dropped opcode. A second instance with a different manufacturer byte runs the same stream, and the point where its read data starts, relative to the first instance, confirms the opcode-dependent collection lengths.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int ADDR_W    = 24;
  localparam int BUF_DEPTH = 5;
  localparam int NEED_W    = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_PROG, ST_READ, ST_COLLECT, ST_RESP} seq_state_e;
  typedef enum logic [1:0] {CL_PROG, CL_READ, CL_ERASE, CL_WRSR} cmd_class_e;
  typedef enum logic [1:0] {ER_SMALL = 2'd0, ER_MED = 2'd1, ER_SECT = 2'd2, ER_ALL = 2'd3} erase_kind_e;
  typedef enum logic [2:0] {AC_NONE, AC_COLLECT, AC_STATUS, AC_ID, AC_WEN, AC_WDIS, AC_CHIP} op_action_e;

  typedef struct packed {
    op_action_e        act;
    cmd_class_e        cls;
    erase_kind_e       ekind;
    logic [NEED_W-1:0] need;
  } op_dec_t;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_ER_S  = 8'h20;
  localparam logic [7:0] OP_QPP   = 8'h32;
  localparam logic [7:0] OP_DOR   = 8'h3B;
  localparam logic [7:0] OP_ER_M  = 8'h52;
  localparam logic [7:0] OP_QOR   = 8'h6B;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_DPP   = 8'hA2;
  localparam logic [7:0] OP_DIOR  = 8'hBB;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam logic [7:0] OP_ER_B  = 8'hD8;
  localparam logic [7:0] OP_QIOR  = 8'hEB;
endpackage

// File: rtl/seq_op_decode.sv
module seq_op_decode
  import spi_seq_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h20
) (
  input  logic [7:0] op_i,
  input  logic       wel_i,
  output op_dec_t    dec_o
);
  localparam bit SHORT_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
  localparam logic [NEED_W-1:0] DIO_NEED = SHORT_IO ? NEED_W'(4) : NEED_W'(5);
  localparam logic [NEED_W-1:0] QIO_NEED = SHORT_IO ? NEED_W'(6) : NEED_W'(8);

  always_comb begin
    dec_o.act   = AC_NONE;
    dec_o.cls   = CL_READ;
    dec_o.ekind = ER_SMALL;
    dec_o.need  = NEED_W'(3);
    unique case (op_i)
      OP_READ: dec_o.act = AC_COLLECT;
      OP_PP, OP_DPP, OP_QPP: begin
        dec_o.act = AC_COLLECT;
        dec_o.cls = CL_PROG;
      end
      OP_ER_S, OP_ER_M, OP_ER_B: begin
        dec_o.act = AC_COLLECT;
        dec_o.cls = CL_ERASE;
        dec_o.ekind = (op_i == OP_ER_S) ? ER_SMALL : (op_i == OP_ER_M) ? ER_MED : ER_SECT;
      end
      OP_FREAD, OP_DOR, OP_QOR: begin
        dec_o.act  = AC_COLLECT;
        dec_o.need = NEED_W'(4);
      end
      OP_DIOR: begin
        dec_o.act  = AC_COLLECT;
        dec_o.need = DIO_NEED;
      end
      OP_QIOR: begin
        dec_o.act  = AC_COLLECT;
        dec_o.need = QIO_NEED;
      end
      OP_WRSR: begin
        dec_o.act  = wel_i ? AC_COLLECT : AC_NONE;
        dec_o.cls  = CL_WRSR;
        dec_o.need = NEED_W'(1);
      end
      OP_WREN: dec_o.act = AC_WEN;
      OP_WRDI: dec_o.act = AC_WDIS;
      OP_RDSR: dec_o.act = AC_STATUS;
      OP_ID:   dec_o.act = AC_ID;
      OP_CHIP: dec_o.act = AC_CHIP;
      default: dec_o.act = AC_NONE;
    endcase
  end
endmodule

// File: rtl/seq_resp_buf.sv
module seq_resp_buf
  import spi_seq_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [DEPTH-1:0][7:0] load_data_i,
  input  logic [CNT_W-1:0]      load_len_i,
  input  logic                  pop_i,
  input  logic                  clear_i,
  output logic [7:0]            byte_o,
  output logic                  last_o
);
  logic [DEPTH-1:0][7:0] mem_q;
  logic [CNT_W-1:0]      pos_q, len_q;
  logic [CNT_W-1:0]      pos_inc;

  assign pos_inc = pos_q + CNT_W'(1);
  assign byte_o  = (pos_q < CNT_W'(DEPTH)) ? mem_q[pos_q] : 8'h00;
  assign last_o  = (pos_inc == len_q);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem_q[g] <= 8'h00;
      else if (load_i) mem_q[g] <= load_data_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      pos_q <= '0;
      len_q <= load_len_i;
    end else if (pop_i) begin
      pos_q <= last_o ? '0 : pos_inc;
    end else if (clear_i) begin
      pos_q <= '0;
    end
  end
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr
  import spi_seq_pkg::*;
#(
  parameter int MEM_BYTES = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   nxt;

  assign nxt    = {1'b0, addr_q} + (ADDR_W+1)'(1);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (inc_i)  addr_q <= (wrap_i && nxt >= LIMIT) ? '0 : nxt[ADDR_W-1:0];
  end
endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int          MEM_BYTES = 65536,
  parameter logic [23:0] ID_CODE   = 24'h20BA18,
  parameter logic [15:0] EXT_ID    = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              erase_req_o,
  output logic [1:0]        erase_kind_o,
  output logic [ADDR_W-1:0] erase_addr_o
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [CNT_W-1:0] ID_LEN = (EXT_ID != 16'h0000) ? CNT_W'(5) : CNT_W'(3);

  seq_state_e        state_q, state_d, state_eff;
  logic              cs_q, select, accept;
  logic [NEED_W-1:0] cnt_q, cnt_d, cnt_eff, cnt_inc, need_q, need_d;
  cmd_class_e        cls_q, cls_d;
  erase_kind_e       ekind_q, ekind_d;
  logic [ADDR_W-1:0] sh_q, sh_d, sh_nxt;
  logic              wel_q, wel_d;

  logic              txv_d, pr_d, er_d;
  logic [7:0]        tx_d, pd_d;
  logic [ADDR_W-1:0] pa_d, ea_d;
  logic [1:0]        ek_d;

  op_dec_t                   dec;
  logic                      buf_load, buf_pop, buf_last;
  logic [BUF_DEPTH-1:0][7:0] buf_data;
  logic [CNT_W-1:0]          buf_len;
  logic [7:0]                buf_byte;
  logic                      ctr_load, ctr_inc, ctr_wrap;
  logic [ADDR_W-1:0]         cur_addr;

  assign select    = cs_q & ~cs_ni;
  assign accept    = rx_valid_i & ~cs_ni;
  assign state_eff = select ? ST_IDLE : state_q;
  assign cnt_eff   = select ? '0 : cnt_q;
  assign cnt_inc   = cnt_eff + NEED_W'(1);
  assign sh_nxt    = (cnt_eff < NEED_W'(3)) ? {sh_q[ADDR_W-9:0], rx_byte_i} : sh_q;
  assign mem_addr_o = cur_addr;

  seq_op_decode #(.MFR_ID(ID_CODE[23:16])) u_dec (
    .op_i  (rx_byte_i),
    .wel_i (wel_q),
    .dec_o (dec)
  );

  seq_resp_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (buf_load),
    .load_data_i (buf_data),
    .load_len_i  (buf_len),
    .pop_i       (buf_pop),
    .clear_i     (select),
    .byte_o      (buf_byte),
    .last_o      (buf_last)
  );

  seq_addr_ctr #(.MEM_BYTES(MEM_BYTES)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (sh_nxt),
    .inc_i      (ctr_inc),
    .wrap_i     (ctr_wrap),
    .addr_o     (cur_addr)
  );

  always_comb begin
    state_d  = state_eff;
    cnt_d    = cnt_eff;
    need_d   = need_q;
    cls_d    = cls_q;
    ekind_d  = ekind_q;
    sh_d     = sh_q;
    wel_d    = wel_q;
    txv_d    = accept;
    tx_d     = tx_byte_o;
    pr_d     = 1'b0;
    pa_d     = prog_addr_o;
    pd_d     = prog_data_o;
    er_d     = 1'b0;
    ek_d     = erase_kind_o;
    ea_d     = erase_addr_o;
    buf_load = 1'b0;
    buf_pop  = 1'b0;
    buf_data = '0;
    buf_len  = '0;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    ctr_wrap = 1'b0;
    if (accept) begin
      tx_d = 8'h00;
      unique case (state_eff)
        ST_IDLE: begin
          unique case (dec.act)
            AC_COLLECT: begin
              state_d = ST_COLLECT;
              cnt_d   = '0;
              need_d  = dec.need;
              cls_d   = dec.cls;
              ekind_d = dec.ekind;
            end
            AC_STATUS: begin
              buf_load    = 1'b1;
              buf_data[0] = {6'b0, wel_q, 1'b0};
              buf_len     = CNT_W'(1);
              state_d     = ST_RESP;
            end
            AC_ID: begin
              buf_load    = 1'b1;
              buf_data[0] = ID_CODE[23:16];
              buf_data[1] = ID_CODE[15:8];
              buf_data[2] = ID_CODE[7:0];
              buf_data[3] = EXT_ID[15:8];
              buf_data[4] = EXT_ID[7:0];
              buf_len     = ID_LEN;
              state_d     = ST_RESP;
            end
            AC_WEN:  wel_d = 1'b1;
            AC_WDIS: wel_d = 1'b0;
            AC_CHIP: begin
              if (wel_q) begin
                er_d = 1'b1;
                ek_d = ER_ALL;
                ea_d = '0;
              end
            end
            default: ;
          endcase
        end
        ST_COLLECT: begin
          sh_d  = sh_nxt;
          cnt_d = cnt_inc;
          if (cnt_inc == need_q) begin
            state_d  = ST_IDLE;
            ctr_load = 1'b1;
            unique case (cls_q)
              CL_PROG: state_d = ST_PROG;
              CL_READ: state_d = ST_READ;
              CL_ERASE: begin
                if (wel_q) begin
                  er_d = 1'b1;
                  ek_d = ekind_q;
                  ea_d = sh_nxt;
                end
              end
              default: wel_d = 1'b0;
            endcase
          end
        end
        ST_READ: begin
          tx_d     = mem_data_i;
          ctr_inc  = 1'b1;
          ctr_wrap = 1'b1;
        end
        ST_PROG: begin
          pr_d    = 1'b1;
          pa_d    = cur_addr;
          pd_d    = rx_byte_i;
          ctr_inc = 1'b1;
        end
        ST_RESP: begin
          tx_d    = buf_byte;
          buf_pop = 1'b1;
          if (buf_last) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cs_q         <= 1'b1;
      cnt_q        <= '0;
      need_q       <= '0;
      cls_q        <= CL_READ;
      ekind_q      <= ER_SMALL;
      sh_q         <= '0;
      wel_q        <= 1'b0;
      tx_valid_o   <= 1'b0;
      tx_byte_o    <= 8'h00;
      prog_req_o   <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= 8'h00;
      erase_req_o  <= 1'b0;
      erase_kind_o <= 2'd0;
      erase_addr_o <= '0;
    end else begin
      state_q      <= state_d;
      cs_q         <= cs_ni;
      cnt_q        <= cnt_d;
      need_q       <= need_d;
      cls_q        <= cls_d;
      ekind_q      <= ekind_d;
      sh_q         <= sh_d;
      wel_q        <= wel_d;
      tx_valid_o   <= txv_d;
      tx_byte_o    <= tx_d;
      prog_req_o   <= pr_d;
      prog_addr_o  <= pa_d;
      prog_data_o  <= pd_d;
      erase_req_o  <= er_d;
      erase_kind_o <= ek_d;
      erase_addr_o <= ea_d;
    end
  end
endmodule

// File: rtl/spi_flash_cmd_seq_chk.sv
module spi_flash_cmd_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        rx_valid_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_byte_o,
  input logic        prog_req_o,
  input logic        erase_req_o,
  input logic [1:0]  erase_kind_o,
  input logic [23:0] erase_addr_o
);
  // R2
  byte_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !cs_ni) |=> tx_valid_o);

  // R2
  no_spur_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_i && !cs_ni) |=> !tx_valid_o);

  // R2
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !(prog_req_o || erase_req_o));

  // R7
  prog_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (tx_valid_o && tx_byte_o == 8'h00 && !erase_req_o));

  // R11
  erase_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> (tx_valid_o && tx_byte_o == 8'h00));

  // R11
  chip_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && erase_kind_o == 2'd3) |-> (erase_addr_o == 24'h0));
endmodule

bind spi_flash_cmd_seq spi_flash_cmd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .rx_valid_i   (rx_valid_i),
  .tx_valid_o   (tx_valid_o),
  .tx_byte_o    (tx_byte_o),
  .prog_req_o   (prog_req_o),
  .erase_req_o  (erase_req_o),
  .erase_kind_o (erase_kind_o),
  .erase_addr_o (erase_addr_o)
);

// File: tb/sim_spi_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_spi_flash_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  logic        txv0, txv1, pr0, pr1, er0, er1;
  logic [7:0]  tx0, tx1, pd0, pd1, md0, md1;
  logic [23:0] ma0, ma1, pa0, pa1, ea0, ea1;
  logic [1:0]  ek0, ek1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] g0, g1;
  logic gv0, gpr, ger;
  logic [23:0] gpa, gea;
  logic [7:0] gpd;
  logic [1:0] gek;

  always #2.5 clk = ~clk;

  // array model: byte = addr[7:0] ^ addr[15:8] ^ 0xA5
  assign md0 = ma0[7:0] ^ ma0[15:8] ^ 8'hA5;
  assign md1 = ma1[7:0] ^ ma1[15:8] ^ 8'hA5;

  spi_flash_cmd_seq #(.MEM_BYTES(256), .ID_CODE(24'h20BA18), .EXT_ID(16'h4D01)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(txv0), .tx_byte_o(tx0), .mem_addr_o(ma0), .mem_data_i(md0),
    .prog_req_o(pr0), .prog_addr_o(pa0), .prog_data_o(pd0),
    .erase_req_o(er0), .erase_kind_o(ek0), .erase_addr_o(ea0));

  spi_flash_cmd_seq #(.MEM_BYTES(256), .ID_CODE(24'hEF4017), .EXT_ID(16'h0000)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(txv1), .tx_byte_o(tx1), .mem_addr_o(ma1), .mem_data_i(md1),
    .prog_req_o(pr1), .prog_addr_o(pa1), .prog_data_o(pd1),
    .erase_req_o(er1), .erase_kind_o(ek1), .erase_addr_o(ea1));

  task automatic chk(input int req, input logic [23:0] got, input logic [23:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    cs_n = 1'b0;
    rx_valid = 1'b1;
    rx_byte = b;
    @(negedge clk);
    g0 = tx0; g1 = tx1; gv0 = txv0;
    gpr = pr0; gpa = pa0; gpd = pd0;
    ger = er0; gek = ek0; gea = ea0;
    rx_valid = 1'b0;
  endtask

  task automatic cs_cycle();
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  // {ctl[1:0], req[3:0], byte[7:0], expected u0 response[7:0]}; ctl 2 = chip-select cycle
  localparam int NV = 53;
  localparam logic [21:0] TBL [NV] = '{
    {2'd1,4'd8,8'h05,8'h00}, {2'd1,4'd1,8'h00,8'h00},                          // R1 R8
    {2'd1,4'd8,8'h06,8'h00}, {2'd1,4'd8,8'h05,8'h00}, {2'd1,4'd8,8'h00,8'h02}, // R8
    {2'd1,4'd8,8'h04,8'h00}, {2'd1,4'd8,8'h05,8'h00}, {2'd1,4'd8,8'h00,8'h00}, // R8
    {2'd1,4'd9,8'h9F,8'h00}, {2'd1,4'd9,8'h00,8'h20}, {2'd1,4'd9,8'h00,8'hBA}, // R9
    {2'd1,4'd9,8'h00,8'h18}, {2'd1,4'd9,8'h00,8'h4D}, {2'd1,4'd9,8'h00,8'h01},
    {2'd1,4'd9,8'h05,8'h00}, {2'd1,4'd9,8'h00,8'h00},
    {2'd1,4'd3,8'h03,8'h00}, {2'd1,4'd3,8'h00,8'h00}, {2'd1,4'd3,8'h00,8'h00}, // R3
    {2'd1,4'd3,8'h10,8'h00}, {2'd1,4'd3,8'h00,8'hB5}, {2'd1,4'd3,8'h00,8'hB4},
    {2'd2,4'd0,8'h00,8'h00},
    {2'd1,4'd6,8'h03,8'h00}, {2'd1,4'd6,8'h00,8'h00}, {2'd1,4'd6,8'h00,8'h00}, // R6
    {2'd1,4'd6,8'hFE,8'h00}, {2'd1,4'd6,8'h00,8'h5B}, {2'd1,4'd6,8'h00,8'h5A},
    {2'd1,4'd6,8'h00,8'hA5}, {2'd2,4'd0,8'h00,8'h00},
    {2'd1,4'd4,8'h0B,8'h00}, {2'd1,4'd4,8'h00,8'h00}, {2'd1,4'd4,8'h00,8'h00}, // R4
    {2'd1,4'd4,8'h20,8'h00}, {2'd1,4'd4,8'hFF,8'h00}, {2'd1,4'd4,8'h00,8'h85},
    {2'd2,4'd0,8'h00,8'h00},
    {2'd1,4'd5,8'hBB,8'h00}, {2'd1,4'd5,8'h00,8'h00}, {2'd1,4'd5,8'h00,8'h00}, // R5
    {2'd1,4'd5,8'h30,8'h00}, {2'd1,4'd5,8'h00,8'h00}, {2'd1,4'd5,8'h00,8'h00},
    {2'd1,4'd5,8'h00,8'h95}, {2'd2,4'd0,8'h00,8'h00},
    {2'd1,4'd12,8'h00,8'h00}, {2'd1,4'd12,8'h7E,8'h00},                         // R12
    {2'd1,4'd12,8'h05,8'h00}, {2'd1,4'd12,8'h00,8'h00},
    {2'd1,4'd10,8'h01,8'h00}, {2'd1,4'd10,8'h05,8'h00}, {2'd1,4'd10,8'h00,8'h00} // R10
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, {23'b0, txv0}, 24'h0, "tx_valid after reset");
    chk(1, {16'b0, tx0}, 24'h0, "tx_byte after reset");
    chk(1, {22'b0, pr0, er0}, 24'h0, "engine requests after reset");
    cs_n = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][21:20] == 2'd2) cs_cycle();
      else begin
        send(TBL[i][15:8]);
        chk(int'(TBL[i][19:16]), {16'b0, g0}, {16'b0, TBL[i][7:0]}, "table response");
        chk(2, {23'b0, gv0}, 24'h1, "response strobe");
      end
    end

    // R10 WRSR with latch set clears it
    send(8'h06); send(8'h05); send(8'h00);
    chk(10, {16'b0, g0}, 24'h02, "latch set before WRSR");
    send(8'h01); send(8'h55);
    chk(10, {16'b0, g0}, 24'h00, "WRSR data byte response");
    send(8'h05); send(8'h00);
    chk(10, {16'b0, g0}, 24'h00, "latch after WRSR");

    // R7 page program forwarding
    cs_cycle();
    send(8'h06);
    send(8'h02); send(8'h00); send(8'h01); send(8'h23);
    chk(7, {23'b0, gpr}, 24'h0, "no program during address");
    send(8'hAA);
    chk(7, {23'b0, gpr}, 24'h1, "program strobe");
    chk(7, gpa, 24'h000123, "program address");
    chk(7, {16'b0, gpd}, 24'hAA, "program data");
    chk(7, {16'b0, g0}, 24'h00, "program response");
    send(8'h55);
    chk(7, gpa, 24'h000124, "program address advance");
    chk(7, {16'b0, gpd}, 24'h55, "program data 2");
    cs_cycle();
    send(8'h32); send(8'h00); send(8'h00); send(8'h07); send(8'h3C);
    chk(7, {23'b0, gpr}, 24'h1, "quad program strobe");
    chk(7, gpa, 24'h000007, "quad program address");
    cs_cycle();

    // R11 erases
    send(8'h04);
    send(8'h20); send(8'h00); send(8'h10); send(8'h00);
    chk(11, {23'b0, ger}, 24'h0, "erase blocked without latch");
    send(8'h06);
    send(8'h20); send(8'h00); send(8'h10); send(8'h00);
    chk(11, {23'b0, ger}, 24'h1, "small erase strobe");
    chk(11, {22'b0, gek}, 24'h0, "small erase kind");
    chk(11, gea, 24'h001000, "small erase address");
    send(8'h52); send(8'h00); send(8'h80); send(8'h00);
    chk(11, {22'b0, gek}, 24'h1, "medium erase kind");
    chk(11, gea, 24'h008000, "medium erase address");
    send(8'hD8); send(8'h01); send(8'h00); send(8'h00);
    chk(11, {22'b0, gek}, 24'h2, "sector erase kind");
    chk(11, gea, 24'h010000, "sector erase address");
    send(8'hC7);
    chk(11, {23'b0, ger}, 24'h1, "chip erase strobe");
    chk(11, {22'b0, gek}, 24'h3, "chip erase kind");
    send(8'h04); send(8'hC7);
    chk(11, {23'b0, ger}, 24'h0, "chip erase blocked");

    // R5 collection length depends on manufacturer byte (u1 uses 0xEF)
    cs_cycle();
    send(8'hBB); send(8'h00); send(8'h00); send(8'h30); send(8'h00);
    send(8'h00);
    chk(5, {16'b0, g1}, 24'h95, "dual io data, short form");
    chk(5, {16'b0, g0}, 24'h00, "dual io fifth byte, long form");
    send(8'h00);
    chk(5, {16'b0, g0}, 24'h95, "dual io data, long form");
    chk(5, {16'b0, g1}, 24'h94, "dual io second data, short form");
    cs_cycle();
    send(8'hEB); send(8'h00); send(8'h00); send(8'h31); send(8'h00); send(8'h00); send(8'h00);
    send(8'h00);
    chk(5, {16'b0, g1}, 24'h94, "quad io data, short form");
    chk(5, {16'b0, g0}, 24'h00, "quad io seventh byte, long form");
    cs_cycle();

    // R9 three-byte identification on u1
    send(8'h9F); send(8'h00); send(8'h00); send(8'h00);
    chk(9, {16'b0, g1}, 24'h17, "short id last byte");
    send(8'h9F);
    chk(9, {16'b0, g1}, 24'h00, "idle after short id");
    chk(9, {16'b0, g0}, 24'h4D, "long id fourth byte");
    send(8'h00);
    chk(9, {16'b0, g1}, 24'hEF, "short id restarts");
    cs_cycle();

    // R13 chip-select fall and byte in the same cycle
    send(8'h06);
    send(8'h03); send(8'h00); send(8'h00); send(8'h40); send(8'h00);
    chk(13, {16'b0, g0}, 24'hE5, "read before reselect");
    cs_n = 1'b1;
    @(negedge clk);
    send(8'h05);
    chk(13, {16'b0, g0}, 24'h00, "opcode on select edge");
    send(8'h00);
    chk(13, {16'b0, g0}, 24'h02, "status after select edge");

    // R2 byte while deselected is ignored
    cs_n = 1'b1;
    rx_valid = 1'b1;
    rx_byte = 8'h04;
    @(negedge clk);
    chk(2, {23'b0, txv0}, 24'h0, "no strobe while deselected");
    rx_valid = 1'b0;
    @(negedge clk);
    send(8'h05); send(8'h00);
    chk(2, {16'b0, g0}, 24'h02, "latch kept after ignored byte");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule